// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the drive for a four-common multiplexed LCD panel with 44 segment lines, fed from a 22-byte display memory. It runs from a nominal 32 kHz system clock. From that clock it derives the common time slots and a slow blink phase. It then steps through the four commons, each in turn, at one quarter duty. For every common and segment pin it emits a 2-bit code that names which bias rail the analog pad stage should connect to the pin. The ladder, the followers and the supply adjustment live outside this block.

Software-facing settings arrive as plain level inputs: oscillator enable, display enable, frame-rate select, bias select and a 2-bit blink mode. The block reads the display memory itself through a combinational read port. During each common slot it scans every address once and collects the column needed for the next slot. The collected column is latched at the slot boundary.

Top module: `lcd_mux_driver`

## Requirements
- R1: Level codes are 0=VSS, 1=low intermediate, 2=high intermediate, 3=VLCD. In reset, and on every cycle after a clock edge that sampled `osc_en` low, every common and segment output carries code 3.
- R2: While running, exactly one common carries code 3 or 0 at any time. That common is the selected one. It carries 3 in the first half of its slot and 0 in the second half. The selection advances in the order 0, 1, 2, 3, 0.
- R3: Every unselected common carries code 1 while the selected common is at 3, and code 2 while it is at 0. This holds for both bias settings.
- R4: With `bias_half`=0 (1/3 bias), a segment that is on carries the code opposite the selected common (0 against 3, 3 against 0). A segment that is off carries the adjacent intermediate code (2 against 3, 1 against 0).
- R5: With `bias_half`=1 (1/2 bias), a segment that is on carries the code opposite the selected common. A segment that is off carries the same code as the selected common.
- R6: Memory byte at address a drives segment 2a through bits 3..0 and segment 2a+1 through bits 7..4. Within each nibble, bit c (c=0..3) is the segment's state while common c is selected. A 1 means on.
- R7: With `disp_en`=0 and `osc_en`=1, the commons keep scanning and every segment is driven with its off code.
- R8: One half slot lasts round(SYS_HZ/(8·rate)) cycles. The rate is FR_SLOW_HZ when `frame_fast`=0 and FR_FAST_HZ when it is 1. A full frame of four commons lasts 8 half slots. With the defaults this is 408 cycles or 208 cycles.
- R9: `blink_mode`=0 never blanks. Mode m (1..3) blanks all segments to their off code during the second half of each period of 2^(BLINK_LOG2+m−1) enabled cycles. The period is counted from the cycle `osc_en` went high.
- R10: `ram_addr` never exceeds NUM_SEG/2−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 32 kHz |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | Oscillator enable; low holds all timing and idles the outputs at code 3 |
| disp_en | input | 1 | Display enable; low drives every segment off |
| frame_fast | input | 1 | 0 selects the slow frame rate, 1 the fast one |
| bias_half | input | 1 | 0 selects 1/3 bias coding, 1 selects 1/2 bias coding |
| blink_mode | input | 2 | 0 no blink, 1..3 blink period 2^(BLINK_LOG2+m−1) cycles |
| ram_addr | output | 5 | Display memory read address |
| ram_data | input | 8 | Display memory byte at `ram_addr`, same cycle |
| com_lvl | output | 8 | Common level codes, common c at bits 2c+1..2c |
| seg_lvl | output | 88 | Segment level codes, segment k at bits 2k+1..2k |

## Verification
The bench keeps the default 32768 Hz clock and the 80/160 Hz frame rates. This keeps the real half-slot lengths of 51 and 26 cycles, so the rounding rule and the rate switch are measured at their true values. BLINK_LOG2 is lowered to 8, which shortens the blink periods to 256, 512 and 1024 cycles. With that setting, both blink phases of all three modes fit within a short run. NUM_SEG stays at 44, so the last memory address and the pairing of SEG42/SEG43 are exercised.

// File: rtl/lcdseq_pkg.sv
// Shared level codes and derived timing helpers for the LCD drive sequencer.
// Assumes a fixed 1/4 duty panel (four commons).
package lcdseq_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_VSS  = 2'd0;
    localparam lvl_t LVL_LO   = 2'd1;
    localparam lvl_t LVL_HI   = 2'd2;
    localparam lvl_t LVL_VLCD = 2'd3;

    localparam int NUM_COM = 4;

    // Half-slot length in clocks, rounded to nearest: eight half slots per frame.
    function automatic int half_slot_div(input int sys_hz, input int rate_hz);
        return (sys_hz + 4 * rate_hz) / (8 * rate_hz);
    endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
// Timebase: divides the system clock into half-slot ticks for the chosen
// frame rate, and runs the blink counter that yields the blanking phase.
// Assumes FR_SLOW_HZ <= FR_FAST_HZ. All state is cleared while run is low.
module lcdseq_timebase #(
    parameter int SYS_HZ     = 32768,
    parameter int FR_SLOW_HZ = 80,
    parameter int FR_FAST_HZ = 160,
    parameter int BLINK_LOG2 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       fast,
    input  logic [1:0] blink_mode,
    output logic       half_tick,
    output logic       blank
);
    localparam int DIV_SLOW = lcdseq_pkg::half_slot_div(SYS_HZ, FR_SLOW_HZ);
    localparam int DIV_FAST = lcdseq_pkg::half_slot_div(SYS_HZ, FR_FAST_HZ);
    localparam int DIV_W    = $clog2(DIV_SLOW + 1);
    localparam int BCNT_W   = BLINK_LOG2 + 2;

    logic [DIV_W-1:0]  div_cnt;
    logic [DIV_W-1:0]  div_last;
    logic [BCNT_W-1:0] blk_cnt;

    // Select the terminal count of the half-slot divider.
    always_comb begin
        div_last = fast ? DIV_W'(DIV_FAST - 1) : DIV_W'(DIV_SLOW - 1);
    end

    // A rate change mid-count wraps at once if the count is already past the end.
    assign half_tick = run && (div_cnt >= div_last);

    // Half-slot divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (half_tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Free-running blink counter, restarted whenever the oscillator stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            blk_cnt <= '0;
        end else begin
            blk_cnt <= blk_cnt + 1'b1;
        end
    end

    // Blanking phase: upper half of the period chosen by the blink mode.
    always_comb begin
        case (blink_mode)
            2'd1:    blank = blk_cnt[BLINK_LOG2-1];
            2'd2:    blank = blk_cnt[BLINK_LOG2];
            2'd3:    blank = blk_cnt[BLINK_LOG2+1];
            default: blank = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcdseq_scan.sv
// Common scanner: tracks the selected common and which half of its slot is
// active. It flags the last tick of each slot so the segment column can be swapped.
// Assumes half_tick is a single-cycle pulse.
module lcdseq_scan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       half_tick,
    output logic [1:0] slot,
    output logic       half,
    output logic       slot_end
);
    assign slot_end = half_tick && half;

    // Advance half, then slot, on each half-slot tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot <= 2'd0;
            half <= 1'b0;
        end else if (half_tick) begin
            half <= ~half;
            if (half) begin
                slot <= slot + 2'd1;
            end
        end
    end

endmodule

// File: rtl/lcdseq_fetch.sv
// Column fetch: during each slot it scans every memory address once and
// gathers the segment states for the following common into a shadow column.
// The shadow column moves into the active column at the slot boundary.
// Assumes ram_data is valid in the same cycle as ram_addr, and that a slot
// lasts more than NUM_SEG/2 cycles.
module lcdseq_fetch #(
    parameter int NUM_SEG = 44
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      slot_end,
    input  logic [1:0]                slot,
    input  logic [7:0]                ram_data,
    output logic [$clog2(NUM_SEG/2)-1:0] ram_addr,
    output logic [NUM_SEG-1:0]        seg_on
);
    localparam int NUM_PAIR = NUM_SEG / 2;
    localparam int AW       = $clog2(NUM_PAIR);

    logic [AW-1:0]      addr_q;
    logic               busy_q;
    logic [1:0]         tgt;
    logic [NUM_SEG-1:0] shadow;

    assign tgt      = slot + 2'd1;
    assign ram_addr = addr_q;

    // Address walker: restarts at each slot boundary and parks at the last address.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            addr_q <= '0;
            busy_q <= 1'b1;
        end else if (slot_end) begin
            addr_q <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (addr_q == AW'(NUM_PAIR - 1)) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    generate
        for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
            // Capture the even and odd segment bits for the target common.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow[2*p]   <= 1'b0;
                    shadow[2*p+1] <= 1'b0;
                end else if (run && busy_q && !slot_end && addr_q == AW'(p)) begin
                    shadow[2*p]   <= ram_data[{1'b0, tgt}];
                    shadow[2*p+1] <= ram_data[{1'b1, tgt}];
                end
            end
        end
    endgenerate

    // Active column swap at the slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seg_on <= '0;
        end else if (slot_end) begin
            seg_on <= shadow;
        end
    end

endmodule

// File: rtl/lcdseq_drive.sv
// Output stage: turns the scan state, the active column and the enables into
// registered level codes for every common and segment pin.
// Assumes codes 1 and 2 both mean the midpoint when 1/2 bias is selected.
module lcdseq_drive #(
    parameter int NUM_SEG = 44
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 disp_en,
    input  logic                 blank,
    input  logic                 bias_half,
    input  logic [1:0]           slot,
    input  logic                 half,
    input  logic [NUM_SEG-1:0]   seg_on,
    output logic [2*lcdseq_pkg::NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    import lcdseq_pkg::*;

    logic visible;
    lvl_t seg_on_code;
    lvl_t seg_off_code;

    assign visible = disp_en && !blank;

    // Segment codes shared by all pins for the current half slot and bias.
    always_comb begin
        seg_on_code  = half ? LVL_VLCD : LVL_VSS;
        if (bias_half) begin
            seg_off_code = half ? LVL_VSS : LVL_VLCD;
        end else begin
            seg_off_code = half ? LVL_LO : LVL_HI;
        end
    end

    generate
        for (genvar c = 0; c < NUM_COM; c++) begin : g_com
            // Common pin: full swing when selected, inner pair otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    com_lvl[2*c +: 2] <= LVL_VLCD;
                end else if (slot == 2'(c)) begin
                    com_lvl[2*c +: 2] <= half ? LVL_VSS : LVL_VLCD;
                end else begin
                    com_lvl[2*c +: 2] <= half ? LVL_HI : LVL_LO;
                end
            end
        end

        for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
            // Segment pin: on or off code from the column and the enables.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    seg_lvl[2*k +: 2] <= LVL_VLCD;
                end else if (visible && seg_on[k]) begin
                    seg_lvl[2*k +: 2] <= seg_on_code;
                end else begin
                    seg_lvl[2*k +: 2] <= seg_off_code;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_mux_driver.sv
// Top of the multiplexed LCD drive sequencer: timebase, common scanner,
// column fetch and output stage. It produces 2-bit level codes per pin.
// Assumes a combinational display memory read port and 1/4 duty.
module lcd_mux_driver #(
    parameter int NUM_SEG    = 44,
    parameter int SYS_HZ     = 32768,
    parameter int FR_SLOW_HZ = 80,
    parameter int FR_FAST_HZ = 160,
    parameter int BLINK_LOG2 = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          osc_en,
    input  logic                          disp_en,
    input  logic                          frame_fast,
    input  logic                          bias_half,
    input  logic [1:0]                    blink_mode,
    output logic [$clog2(NUM_SEG/2)-1:0]  ram_addr,
    input  logic [7:0]                    ram_data,
    output logic [7:0]                    com_lvl,
    output logic [2*NUM_SEG-1:0]          seg_lvl
);
    logic               half_tick;
    logic               blank;
    logic [1:0]         slot;
    logic               half;
    logic               slot_end;
    logic [NUM_SEG-1:0] seg_on;

    lcdseq_timebase #(
        .SYS_HZ    (SYS_HZ),
        .FR_SLOW_HZ(FR_SLOW_HZ),
        .FR_FAST_HZ(FR_FAST_HZ),
        .BLINK_LOG2(BLINK_LOG2)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (osc_en),
        .fast      (frame_fast),
        .blink_mode(blink_mode),
        .half_tick (half_tick),
        .blank     (blank)
    );

    lcdseq_scan u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (osc_en),
        .half_tick(half_tick),
        .slot     (slot),
        .half     (half),
        .slot_end (slot_end)
    );

    lcdseq_fetch #(.NUM_SEG(NUM_SEG)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (osc_en),
        .slot_end(slot_end),
        .slot    (slot),
        .ram_data(ram_data),
        .ram_addr(ram_addr),
        .seg_on  (seg_on)
    );

    lcdseq_drive #(.NUM_SEG(NUM_SEG)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (osc_en),
        .disp_en  (disp_en),
        .blank    (blank),
        .bias_half(bias_half),
        .slot     (slot),
        .half     (half),
        .seg_on   (seg_on),
        .com_lvl  (com_lvl),
        .seg_lvl  (seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_driver_chk.sv
// Checker for the LCD drive sequencer. It observes only ports and relates the
// output codes to the enables sampled at the same clock edges.
module lcd_mux_driver_chk #(
    parameter int NUM_SEG = 44
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         osc_en,
    input logic                         disp_en,
    input logic                         bias_half,
    input logic [$clog2(NUM_SEG/2)-1:0] ram_addr,
    input logic [7:0]                   com_lvl,
    input logic [2*NUM_SEG-1:0]         seg_lvl
);
    logic       run_q, disp_q, bias_q, prev_ok;
    logic [1:0] prev_sel;

    function automatic int n_sel(input logic [7:0] cv);
        int n = 0;
        for (int c = 0; c < 4; c++) begin
            if (cv[2*c +: 2] == 2'd0 || cv[2*c +: 2] == 2'd3) n++;
        end
        return n;
    endfunction

    function automatic logic [1:0] sel_idx(input logic [7:0] cv);
        logic [1:0] r = 2'd0;
        for (int c = 3; c >= 0; c--) begin
            if (cv[2*c +: 2] == 2'd0 || cv[2*c +: 2] == 2'd3) r = 2'(c);
        end
        return r;
    endfunction

    function automatic logic unsel_ok(input logic [7:0] cv);
        logic [1:0] s   = sel_idx(cv);
        logic [1:0] exp = (cv[2*s +: 2] == 2'd3) ? 2'd1 : 2'd2;
        logic ok = 1'b1;
        for (int c = 0; c < 4; c++) begin
            if (2'(c) != s && cv[2*c +: 2] != exp) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic segs_in(input logic [2*NUM_SEG-1:0] sv,
                                     input logic [1:0] a, input logic [1:0] b);
        logic ok = 1'b1;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (sv[2*k +: 2] != a && sv[2*k +: 2] != b) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [1:0] sel_code(input logic [7:0] cv);
        return cv[2*sel_idx(cv) +: 2];
    endfunction

    // Mirror the enables sampled at the same edges as the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            disp_q   <= 1'b0;
            bias_q   <= 1'b0;
            prev_ok  <= 1'b0;
            prev_sel <= 2'd0;
        end else begin
            run_q    <= osc_en;
            disp_q   <= disp_en;
            bias_q   <= bias_half;
            prev_ok  <= run_q;
            prev_sel <= sel_idx(com_lvl);
        end
    end

    p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (com_lvl == '1 && seg_lvl == '1));

    p_one_common_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> n_sel(com_lvl) == 1);

    p_com_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && prev_ok && sel_idx(com_lvl) != prev_sel)
            |-> sel_idx(com_lvl) == prev_sel + 2'd1);

    p_unsel_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && n_sel(com_lvl) == 1) |-> unsel_ok(com_lvl));

    p_seg_third_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !bias_q) |->
            (sel_code(com_lvl) == 2'd3 ? segs_in(seg_lvl, 2'd0, 2'd2)
                                       : segs_in(seg_lvl, 2'd3, 2'd1)));

    p_seg_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && bias_q) |-> segs_in(seg_lvl, 2'd0, 2'd3));

    p_disp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !disp_q) |->
            (sel_code(com_lvl) == 2'd3
                ? segs_in(seg_lvl, bias_q ? 2'd3 : 2'd2, bias_q ? 2'd3 : 2'd2)
                : segs_in(seg_lvl, bias_q ? 2'd0 : 2'd1, bias_q ? 2'd0 : 2'd1)));

    p_addr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ram_addr) < NUM_SEG / 2);

endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .disp_en  (disp_en),
    .bias_half(bias_half),
    .ram_addr (ram_addr),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
);

// File: tb/tb_lcd_mux_driver.sv
`timescale 1ns/1ps
// Bench for the LCD drive sequencer: random memory and settings from a fixed
// seed plus directed cases. Expected codes are derived from the requirements.
module tb_lcd_mux_driver;
    localparam int NSEG  = 44;
    localparam int NPAIR = 22;
    localparam int BLK   = 8;
    localparam int DIV_S = (32768 + 4 * 80) / (8 * 80);
    localparam int DIV_F = (32768 + 4 * 160) / (8 * 160);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            osc_en = 1'b0, disp_en = 1'b0, frame_fast = 1'b0, bias_half = 1'b0;
    logic [1:0]      blink_mode = 2'd0;
    logic [4:0]      ram_addr;
    logic [7:0]      ram_data;
    logic [7:0]      com_lvl;
    logic [2*NSEG-1:0] seg_lvl;
    logic [7:0]      mem [NPAIR];
    int              kcnt = 0;
    int              n_chk = 0, n_bad = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    assign ram_data = (ram_addr < 5'(NPAIR)) ? mem[ram_addr] : 8'h00;

    lcd_mux_driver #(.BLINK_LOG2(BLK)) dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .disp_en(disp_en),
        .frame_fast(frame_fast), .bias_half(bias_half), .blink_mode(blink_mode),
        .ram_addr(ram_addr), .ram_data(ram_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // Bench copy of the enabled-cycle count that defines the blink period.
    always @(posedge clk) kcnt <= osc_en ? kcnt + 1 : 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bitof(input int v, input int b);
        return (v >> b) & 1;
    endfunction

    task automatic fill(input int kind);
        for (int i = 0; i < NPAIR; i++) begin
            case (kind)
                0: mem[i] = 8'($urandom);
                1: mem[i] = 8'h00;
                2: mem[i] = 8'hFF;
                default: mem[i] = (i == NPAIR - 1) ? 8'h80 : ((i == 0) ? 8'h01 : 8'h00);
            endcase
        end
    endtask

    // Sample repeatedly and compare commons and segments to the model.
    task automatic window(input string req, input int nsamp, input int step);
        int prev = -1;
        for (int s = 0; s < nsamp; s++) begin
            int nsel = 0, sidx = 0, bad = 0, half, first_act = 0, first_exp = 0;
            bit vis_all, skip = 1'b0;
            repeat (step) @(negedge clk);
            chk(ram_addr < 5'(NPAIR), "R10", int'(ram_addr), NPAIR - 1);
            for (int c = 0; c < 4; c++)
                if (com_lvl[2*c +: 2] == 2'd0 || com_lvl[2*c +: 2] == 2'd3) begin
                    nsel++; sidx = c;
                end
            chk(nsel == 1, "R2", nsel, 1);
            if (nsel != 1) continue;
            if (prev >= 0 && prev != sidx) chk(sidx == ((prev + 1) % 4), "R2", sidx, (prev + 1) % 4);
            prev = sidx;
            half = (com_lvl[2*sidx +: 2] == 2'd0);
            for (int c = 0; c < 4; c++)
                if (c != sidx && com_lvl[2*c +: 2] != (half ? 2'd2 : 2'd1)) bad++;
            chk(bad == 0, "R3", bad, 0);
            vis_all = disp_en;
            if (blink_mode != 2'd0) begin
                int b = BLK + int'(blink_mode) - 2;
                int r = kcnt - 1;
                if (bitof(r - 4, b) != bitof(r + 4, b)) skip = 1'b1;
                else if (bitof(r, b) == 1) vis_all = 1'b0;
            end
            if (skip) continue;
            bad = 0;
            for (int k = 0; k < NSEG; k++) begin
                bit on = mem[k / 2][(k % 2) * 4 + sidx];
                logic [1:0] e;
                if (vis_all && on) e = half ? 2'd3 : 2'd0;
                else if (bias_half) e = half ? 2'd0 : 2'd3;
                else e = half ? 2'd1 : 2'd2;
                if (seg_lvl[2*k +: 2] != e) begin
                    if (bad == 0) begin
                        first_act = k * 10 + int'(seg_lvl[2*k +: 2]);
                        first_exp = k * 10 + int'(e);
                    end
                    bad++;
                end
            end
            chk(bad == 0, req, first_act, first_exp);
        end
    endtask

    // Measure cycles between successive selections of common 0.
    task automatic frame_len(input bit fast);
        int n = 0;
        frame_fast = fast;
        repeat (900) @(negedge clk);
        while (com_lvl[1:0] == 2'd3) @(negedge clk);
        while (com_lvl[1:0] != 2'd3) @(negedge clk);
        do begin @(negedge clk); n++; end while (com_lvl[1:0] == 2'd3);
        while (com_lvl[1:0] != 2'd3) begin @(negedge clk); n++; end
        chk(n == 8 * (fast ? DIV_F : DIV_S), "R8", n, 8 * (fast ? DIV_F : DIV_S));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        fill(1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(com_lvl == '1 && seg_lvl == '1, "R1", int'(com_lvl), 255);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(com_lvl == '1 && seg_lvl == '1, "R1", int'(com_lvl), 255);

        fill(0);
        osc_en = 1'b1; disp_en = 1'b1;
        repeat (900) @(negedge clk);
        window("R4", 40, 10);
        bias_half = 1'b1;
        repeat (20) @(negedge clk);
        window("R5", 40, 10);
        bias_half = 1'b0;

        for (int kind = 1; kind <= 3; kind++) begin
            fill(kind);
            repeat (900) @(negedge clk);
            window("R6", 45, 9);
        end

        fill(0);
        repeat (900) @(negedge clk);
        disp_en = 1'b0;
        repeat (20) @(negedge clk);
        window("R7", 40, 10);
        bias_half = 1'b1;
        repeat (20) @(negedge clk);
        window("R7", 40, 10);
        disp_en = 1'b1; bias_half = 1'b0;

        frame_len(1'b0);
        frame_len(1'b1);
        window("R8", 30, 7);
        frame_fast = 1'b0;

        for (int r = 0; r < 4; r++) begin
            fill(0);
            bias_half  = 1'($urandom);
            frame_fast = 1'($urandom);
            repeat (900) @(negedge clk);
            window(bias_half ? "R5" : "R4", 40, 11);
        end
        frame_fast = 1'b0;

        osc_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(com_lvl == '1 && seg_lvl == '1, "R1", int'(com_lvl), 255);
        fill(2);
        bias_half = 1'b0;
        osc_en = 1'b1;
        repeat (900) @(negedge clk);
        for (int m = 1; m <= 3; m++) begin
            blink_mode = 2'(m);
            window("R9", ((1 << (BLK + m - 1)) * 2) / 13 + 2, 13);
        end
        blink_mode = 2'd0;
        window("R9", 40, 13);

        finish_run();
    end

endmodule